// File: doc/BRIEF.md
# External Interrupt Sense and Flag Unit

This unit watches a set of external interrupt pins and one internal timer-overflow event and keeps a pending indication for each of these sources. Every pin has its own two-bit sense field that selects low-level, falling-edge or rising-edge detection, or switches detection off. Pins are brought into the clock domain through a synchronizer, so the unit reacts to a pin regardless of whether the surrounding port logic drives that pin as an input or as an output. Driving the pin as an output is one way to raise a software interrupt.

A pending source raises a request only when the global interrupt enable from the CPU, the enable bit of that source and its pending indication are all set. When more than one request is active, a fixed priority picks the winner and reports its index. A one-cycle vector-acknowledge pulse clears the latched flag of that winner only. Software reaches the sense control, the enables and the flags through a small register port. In the flag register, writing a one to a bit clears that flag.

Top module: `extint_unit`

## Requirements
- R1: The control register at address 0 resets to zero. Bits 1:0 are the pin 0 sense field, bits 3:2 the pin 1 sense field, bit 4 the sleep-mode bit and bit 5 the sleep-enable bit. All of these read back as written, and bits 7:6 always read zero.
- R2: The sense code for a pin is 00 for low level, 01 for detection off, 10 for falling edge and 11 for rising edge.
- R3: In an edge mode, the matching edge of a pin sets that pin's flag. The flag becomes visible after the third rising clock edge that follows the pin change, because the pin passes through two synchronizer stages. The opposite edge does not set the flag.
- R4: In low-level mode a pin has no latched flag. Its pending bit reads one whenever the synchronized pin is low, which is visible after the second clock edge. Neither a software clear nor an acknowledge stops the request while the pin stays low.
- R5: With sense code 01, no pin transition sets the flag.
- R6: A timer-overflow pulse sets the timer flag (flag bit 2) on the next clock edge.
- R7: The flag register is at address 2, with bit 0 for pin 0, bit 1 for pin 1 and bit 2 for the timer. Writing a one to a bit clears that flag, and writing a zero leaves it unchanged. A new event in the same cycle as a clear leaves the flag set.
- R8: The enable register is at address 1, bits 2:0, with the same bit order as the flags. irq_o is high only when gie_i, the enable bit and the pending bit of some source are all one.
- R9: When several sources request at once, pin 0 wins over pin 1 and pin 1 wins over the timer. irq_id_o gives the winner's index: 0 for pin 0, 1 for pin 1, 2 for the timer.
- R10: An ack_i pulse clears only the latched flag of the winning source. An ack_i pulse while irq_o is low changes no flag.
- R11: Address 3 reads zero. Unused bits of the enable and flag registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| tmr_ovf_i | input | 1 | Single-cycle timer overflow event |
| gie_i | input | 1 | Global interrupt enable from the CPU status |
| ack_i | input | 1 | Vector-acknowledge pulse for the current winner |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational on the address |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_id_o | output | ID_W | Index of the winning source |

## Verification
The hardest condition to reach from the ports is a state where all three sources are latched and enabled together, so that each acknowledge must remove exactly one of them in priority order. The bench reaches it by arming both pins for falling edges, dropping both pins in the same cycle as a timer pulse, and only then raising the enables and the global enable. It then acknowledges three times and reads the flag vector after each pulse. A second hard case is a low-level pin that must keep requesting after an acknowledge and after a software clear. The bench reaches it by holding the pin low through both operations.

// File: rtl/extint_pkg.sv
package extint_pkg;
   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] ADDR_EN   = 2'd1;
   localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_OFF  = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int   W       = 2,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("extint_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[0] <= {W{RST_VAL}};
               else        stg_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= {W{RST_VAL}};
               else        stg_q[s] <= stg_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/extint_flag.sv
module extint_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/extint_pin_sense.sv
module extint_pin_sense
   import extint_pkg::*;
#(
   parameter logic RST_VAL = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sync_i,
   input  sense_e mode_i,
   input  logic   clr_i,
   output logic   pend_o
);
   logic prev_q;
   logic fell, rose, hit, flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= sync_i;
   end

   assign fell = prev_q & ~sync_i;
   assign rose = ~prev_q & sync_i;

   always_comb begin
      unique case (mode_i)
         SENSE_FALL: hit = fell;
         SENSE_RISE: hit = rose;
         default:    hit = 1'b0;
      endcase
   end

   extint_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (hit),
      .clr_i (clr_i),
      .q_o   (flag_q)
   );

   assign pend_o = (mode_i == SENSE_LOW) ? ~sync_i : flag_q;
endmodule

// File: rtl/extint_arb.sv
module extint_arb #(
   parameter int NSRC = 3,
   parameter int ID_W = 2
) (
   input  logic [NSRC-1:0] req_i,
   output logic [NSRC-1:0] grant_o,
   output logic [ID_W-1:0] id_o,
   output logic            any_o
);
   always_comb begin
      grant_o = '0;
      id_o    = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            grant_o    = '0;
            grant_o[i] = 1'b1;
            id_o       = ID_W'(i);
         end
      end
   end

   assign any_o = |req_i;
endmodule

// File: rtl/extint_unit.sv
module extint_unit
   import extint_pkg::*;
#(
   parameter int   NUM_PINS    = 2,
   parameter int   DATA_W      = 8,
   parameter int   SYNC_STAGES = 2,
   parameter logic SYNC_RST    = 1'b1,
   localparam int  NSRC        = NUM_PINS + 1,
   localparam int  ID_W        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                tmr_ovf_i,
   input  logic                gie_i,
   input  logic                ack_i,
   input  logic                reg_we_i,
   input  logic [ADDR_W-1:0]   reg_addr_i,
   input  logic [DATA_W-1:0]   reg_wdata_i,
   output logic [DATA_W-1:0]   reg_rdata_o,
   output logic                irq_o,
   output logic [ID_W-1:0]     irq_id_o
);
   localparam int CTRL_W = 2 * NUM_PINS + 2;
   localparam int TMR    = NUM_PINS;

   generate
      if (NUM_PINS < 1 || CTRL_W > DATA_W || NSRC > DATA_W) begin : g_bad_cfg
         $error("extint_unit: register fields do not fit DATA_W");
      end
   endgenerate

   logic [CTRL_W-1:0]   ctrl_q;
   logic [NSRC-1:0]     en_q;
   logic [NSRC-1:0]     pend;
   logic [NSRC-1:0]     req;
   logic [NSRC-1:0]     grant;
   logic [NSRC-1:0]     sw_clr;
   logic [NSRC-1:0]     ack_clr;
   logic [NUM_PINS-1:0] pin_sync;
   logic                unused_wdata;

   assign unused_wdata = ^reg_wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         en_q   <= '0;
      end else if (reg_we_i) begin
         if (reg_addr_i == ADDR_CTRL) ctrl_q <= reg_wdata_i[CTRL_W-1:0];
         if (reg_addr_i == ADDR_EN)   en_q   <= reg_wdata_i[NSRC-1:0];
      end
   end

   assign sw_clr  = (reg_we_i && reg_addr_i == ADDR_FLAG) ? reg_wdata_i[NSRC-1:0] : '0;
   assign ack_clr = (ack_i && irq_o) ? grant : '0;

   extint_sync #(
      .W       (NUM_PINS),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_sync)
   );

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         extint_pin_sense #(
            .RST_VAL (SYNC_RST)
         ) u_sense (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_i (pin_sync[p]),
            .mode_i (sense_e'(ctrl_q[2*p+1 -: 2])),
            .clr_i  (sw_clr[p] | ack_clr[p]),
            .pend_o (pend[p])
         );
      end
   endgenerate

   extint_flag u_tmr_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (tmr_ovf_i),
      .clr_i (sw_clr[TMR] | ack_clr[TMR]),
      .q_o   (pend[TMR])
   );

   assign req = {NSRC{gie_i}} & en_q & pend;

   extint_arb #(
      .NSRC (NSRC),
      .ID_W (ID_W)
   ) u_arb (
      .req_i   (req),
      .grant_o (grant),
      .id_o    (irq_id_o),
      .any_o   (irq_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_addr_i)
         ADDR_CTRL: reg_rdata_o[CTRL_W-1:0] = ctrl_q;
         ADDR_EN:   reg_rdata_o[NSRC-1:0]   = en_q;
         ADDR_FLAG: reg_rdata_o[NSRC-1:0]   = pend;
         default:   reg_rdata_o             = '0;
      endcase
   end
endmodule

// File: rtl/extint_unit_chk.sv
module extint_unit_chk #(
   parameter int NUM_PINS = 2,
   parameter int DATA_W   = 8,
   parameter int ID_W     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tmr_ovf_i,
   input logic              gie_i,
   input logic              ack_i,
   input logic              reg_we_i,
   input logic [1:0]        reg_addr_i,
   input logic              tmr_clr_bit,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic              irq_o,
   input logic [ID_W-1:0]   irq_id_o,
   input logic              en0,
   input logic              pend0,
   input logic              pend_tmr
);
   localparam int NSRC   = NUM_PINS + 1;
   localparam int CTRL_W = 2 * NUM_PINS + 2;

   assert_gie_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_i |-> !irq_o);

   assert_pin0_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (gie_i && en0 && pend0) |-> (irq_o && irq_id_o == '0));

   assert_id_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (int'(irq_id_o) < NSRC));

   assert_tmr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf_i |=> pend_tmr);

   assert_sw_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we_i && reg_addr_i == 2'd2 && tmr_clr_bit && !tmr_ovf_i) |=> !pend_tmr);

   assert_ack_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o && int'(irq_id_o) == NUM_PINS && !tmr_ovf_i) |=> !pend_tmr);

   assert_ctrl_rsvd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == 2'd0) |-> ((reg_rdata_o >> CTRL_W) == '0));

   assert_hole_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == 2'd3) |-> (reg_rdata_o == '0));
endmodule

bind extint_unit extint_unit_chk #(
   .NUM_PINS (NUM_PINS),
   .DATA_W   (DATA_W),
   .ID_W     (ID_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tmr_ovf_i   (tmr_ovf_i),
   .gie_i       (gie_i),
   .ack_i       (ack_i),
   .reg_we_i    (reg_we_i),
   .reg_addr_i  (reg_addr_i),
   .tmr_clr_bit (reg_wdata_i[NUM_PINS]),
   .reg_rdata_o (reg_rdata_o),
   .irq_o       (irq_o),
   .irq_id_o    (irq_id_o),
   .en0         (en_q[0]),
   .pend0       (pend[0]),
   .pend_tmr    (pend[NUM_PINS])
);

// File: tb/sim_extint_unit.sv
module sim_extint_unit;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pin = 2'b11;
   logic       tmr = 1'b0;
   logic       gie = 1'b0;
   logic       ack = 1'b0;
   logic       we = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq;
   logic [1:0] irq_id;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   extint_unit u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (pin),
      .tmr_ovf_i   (tmr),
      .gie_i       (gie),
      .ack_i       (ack),
      .reg_we_i    (we),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .irq_o       (irq),
      .irq_id_o    (irq_id)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0; wdata = 8'd0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic pulse_ack();
      @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      #1;
   endtask

   task automatic pulse_tmr();
      @(negedge clk);
      tmr = 1'b1;
      @(negedge clk);
      tmr = 1'b0;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);

      // Reset state: R1, R8, R7
      rd(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
      rd(2'd1, v); chk("R8 enable reset", v, 8'h00);
      rd(2'd2, v); chk("R7 flags reset", v, 8'h00);
      chk("R8 irq reset", irq, 1'b0);

      // Register layout: R1, R11
      wr(2'd0, 8'hFF); rd(2'd0, v); chk("R1 ctrl reserved bits", v, 8'h3F);
      wr(2'd0, 8'h35); rd(2'd0, v); chk("R1 ctrl readback", v, 8'h35);
      wr(2'd1, 8'hFF); rd(2'd1, v); chk("R11 enable unused bits", v, 8'h07);
      wr(2'd3, 8'hFF); rd(2'd3, v); chk("R11 address 3", v, 8'h00);
      wr(2'd1, 8'h00);

      // Sense sweep: R2 R3 R4 R5 for every pin, mode and direction
      for (int p = 0; p < 2; p++) begin
         for (int m = 0; m < 4; m++) begin
            for (int dir = 0; dir < 2; dir++) begin
               logic start_lvl, end_lvl;
               logic [7:0] ctrl, exp_early, exp_late;
               start_lvl = (dir == 0);
               end_lvl   = ~start_lvl;
               ctrl = (p == 0) ? 8'((1 << 2) | m) : 8'((m << 2) | 1);
               wr(2'd0, ctrl);
               pin[p] = start_lvl;
               cyc(4);
               wr(2'd2, 8'h07);
               @(negedge clk);
               pin[p] = end_lvl;
               exp_late = 8'h00;
               exp_early = 8'h00;
               if (m == 0 && end_lvl == 1'b0) begin
                  exp_late = 8'(1 << p); exp_early = 8'(1 << p);
               end
               if (m == 2 && dir == 0) exp_late = 8'(1 << p);
               if (m == 3 && dir == 1) exp_late = 8'(1 << p);
               cyc(2);
               rd(2'd2, v);
               chk($sformatf("R3 R4 early p%0d m%0d d%0d", p, m, dir), v, exp_early);
               cyc(1);
               rd(2'd2, v);
               chk($sformatf("R2 R3 R5 late p%0d m%0d d%0d", p, m, dir), v, exp_late);
               if (m == 0 && dir == 0) begin
                  wr(2'd2, 8'h07);
                  rd(2'd2, v);
                  chk($sformatf("R4 level survives clear p%0d", p), v, exp_late);
               end
               pin[p] = 1'b1;
               cyc(4);
               wr(2'd2, 8'h07);
            end
         end
      end

      // Timer flag: R6 R7
      wr(2'd0, 8'h05);
      pulse_tmr();
      rd(2'd2, v); chk("R6 timer sets flag", v, 8'h04);
      wr(2'd2, 8'h00); rd(2'd2, v); chk("R7 write zero keeps", v, 8'h04);
      wr(2'd2, 8'h04); rd(2'd2, v); chk("R7 write one clears", v, 8'h00);
      @(negedge clk);
      tmr = 1'b1; we = 1'b1; addr = 2'd2; wdata = 8'h04;
      @(negedge clk);
      tmr = 1'b0; we = 1'b0; wdata = 8'h00;
      rd(2'd2, v); chk("R7 set wins over clear", v, 8'h04);

      // Request gating: R8
      wr(2'd1, 8'h07);
      #1; chk("R8 gie low blocks", irq, 1'b0);
      gie = 1'b1; #1;
      chk("R8 request raised", irq, 1'b1);
      chk("R9 timer id", irq_id, 2'd2);
      wr(2'd1, 8'h03);
      #1; chk("R8 enable off blocks", irq, 1'b0);

      // Ack with no request: R10
      pulse_ack();
      rd(2'd2, v); chk("R10 ack when idle", v, 8'h04);

      // All three latched: R9 R10
      wr(2'd2, 8'h07);
      wr(2'd0, 8'h0A);
      cyc(4);
      wr(2'd2, 8'h07);
      @(negedge clk);
      pin = 2'b00; tmr = 1'b1;
      @(negedge clk);
      tmr = 1'b0;
      cyc(3);
      wr(2'd1, 8'h07);
      #1;
      chk("R9 pin0 wins irq", irq, 1'b1);
      chk("R9 pin0 wins id", irq_id, 2'd0);
      pulse_ack();
      rd(2'd2, v); chk("R10 ack clears pin0 only", v, 8'h06);
      chk("R9 pin1 next", irq_id, 2'd1);
      pulse_ack();
      rd(2'd2, v); chk("R10 ack clears pin1 only", v, 8'h04);
      chk("R9 timer last", irq_id, 2'd2);
      pulse_ack();
      rd(2'd2, v); chk("R10 ack clears timer", v, 8'h00);
      chk("R10 irq drops", irq, 1'b0);

      // Level re-trigger: R4
      wr(2'd0, 8'h04);
      wr(2'd1, 8'h01);
      cyc(3);
      #1;
      chk("R4 level request", irq, 1'b1);
      pulse_ack();
      chk("R4 level after ack", irq, 1'b1);
      pin = 2'b11;
      cyc(3);
      #1;
      chk("R4 level released", irq, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule